// File: doc/BRIEF.md
# Shared-Vector Interrupt Flag Controller

This block collects event pulses from several sources and raises one interrupt request toward a processor core that has a single entry address. Each source has two bits. One is a sticky pending flag that records every event. The other is a per-source enable that only decides whether that flag may drive the request. Source 0 is fed by an internal 8-bit free-running counter, which signals an event when it wraps. The other sources come in as single-cycle pulses on `evt_i`. A parameter mask places some sources in a peripheral group, and those sources also need a group enable before they can raise the request.

Flags, enables and the two control bits (global enable and peripheral-group enable) are written through a small register write port and are always visible on output ports. Software can therefore poll flags while their interrupts are masked. A combined pending vector (flag AND enable) lets a service routine test several sources in one access. When the core accepts the interrupt it pulses `ack_i`, which clears the global enable. A return pulse on `ret_i` sets the global enable again. The request is a level, so any source that is still pending and enabled asserts it again at once.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is applied and after it is released, all flags, all enables, the global enable, the peripheral-group enable and the timer count are zero, and `irq_o` is low.
- R2: An event pulse on a source sets that source's flag on the next clock edge. The state of its enable, the group enable and the global enable has no effect on this. Source k+1 is driven by `evt_i[k]`.
- R3: Each cycle with `tmr_tick_i` high advances the 8-bit counter by one. The tick that moves the counter from FFh to 00h sets flag 0, and the 255 ticks before it do not.
- R4: `irq_o` is high only when the global enable is set and some source has both its flag and its enable set. A source in the peripheral group (mask bits 1 and 2 by default) also needs the peripheral-group enable.
- R5: The request is a level. It stays high for as long as a qualifying flag and enable pair stays true, and it falls in the cycle after the flag is cleared.
- R6: An `ack_i` pulse clears the global enable at the next edge, so `irq_o` falls. `vector_o` reads 04h. When `ack_i` and `ret_i` arrive together, `ack_i` takes priority.
- R7: A `ret_i` pulse sets the global enable at the next edge. If an enabled flag is still pending, `irq_o` is high again in that same cycle.
- R8: A write with `wr_sel_i`=0 updates the flags. Each data bit at 0 clears the matching flag and each data bit at 1 leaves it unchanged, so software can never set a flag. The flags are readable on `flags_o` whatever the enables are.
- R9: When an event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: A write with `wr_sel_i`=1 loads the enables. A write with `wr_sel_i`=2 loads the control bits: data bit 0 is the global enable and data bit 1 is the peripheral-group enable. Enabling a source whose flag is already set raises `irq_o` in the cycle after the write, provided the global enable is set.
- R11: `pending_o` equals `flags_o` AND `enables_o`, bit by bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tmr_tick_i | input | 1 | Count enable for the 8-bit wrap counter |
| evt_i | input | NSRC-1 | Event pulses for sources 1 to NSRC-1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flags, 1 enables, 2 control |
| wr_data_i | input | NSRC | Write data |
| ack_i | input | 1 | Core accepted the interrupt |
| ret_i | input | 1 | Core returned from the service routine |
| irq_o | output | 1 | Level interrupt request |
| vector_o | output | 8 | Fixed entry address, 04h |
| tmr_count_o | output | 8 | Current counter value |
| flags_o | output | NSRC | Pending flags |
| enables_o | output | NSRC | Per-source enables |
| gie_o | output | 1 | Global enable |
| peie_o | output | 1 | Peripheral-group enable |
| pending_o | output | NSRC | Flags AND enables |

## Verification
If the flag register lost an event or let software set a bit, `flags_o` would show it on the cycle after the offending edge. A wrong enable or group gate would show as a wrong level on `irq_o` in that same cycle. A bad global-enable sequence would show on `gie_o` and `irq_o` one edge after `ack_i` or `ret_i`. Collisions are the subtle cases: an event arriving together with a clear, and an acknowledge arriving together with a return. A wrong priority in either case changes the port values after exactly one edge, so each such case is checked at that point.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_EN    = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;

  localparam int unsigned CTRL_GIE_BIT  = 0;
  localparam int unsigned CTRL_PEIE_BIT = 1;
endpackage

// File: rtl/irq_wrap_timer.sv
module irq_wrap_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (tick_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = (cnt_q == CMAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            wr_en_i,
  input  reg_sel_e        wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] flag_o,
  output logic [NSRC-1:0] en_o
);
  logic flag_we, en_we;

  assign flag_we = wr_en_i && (wr_sel_i == SEL_FLAGS);
  assign en_we   = wr_en_i && (wr_sel_i == SEL_EN);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic flag_q, flag_d, en_q;

    // a clear only removes bits; a hardware event always wins
    always_comb begin
      flag_d = flag_q;
      if (flag_we && !wr_data_i[s]) flag_d = 1'b0;
      if (set_i[s]) flag_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else flag_q <= flag_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else if (en_we) en_q <= wr_data_i[s];
    end

    assign flag_o[s] = flag_q;
    assign en_o[s]   = en_q;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pkg::*;
#(
  parameter int unsigned     NSRC        = 4,
  parameter logic [NSRC-1:0] PERIPH_MASK = 4'b0110
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            wr_en_i,
  input  reg_sel_e        wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            gie_o,
  output logic            peie_o,
  output logic [NSRC-1:0] pending_o,
  output logic            irq_o
);
  logic gie_q, gie_d, peie_q, peie_d, ctrl_we;
  logic [NSRC-1:0] qual;

  assign ctrl_we = wr_en_i && (wr_sel_i == SEL_CTRL);

  // priority: acknowledge, then return, then software write
  always_comb begin
    gie_d  = gie_q;
    peie_d = peie_q;
    if (ctrl_we) begin
      gie_d  = wr_data_i[CTRL_GIE_BIT];
      peie_d = wr_data_i[CTRL_PEIE_BIT];
    end
    if (ret_i) gie_d = 1'b1;
    if (ack_i) gie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      peie_q <= 1'b0;
    end else begin
      gie_q  <= gie_d;
      peie_q <= peie_d;
    end
  end

  assign pending_o = flag_i & en_i;

  for (genvar s = 0; s < NSRC; s++) begin : g_qual
    if (PERIPH_MASK[s]) begin : g_periph
      assign qual[s] = pending_o[s] & peie_q;
    end else begin : g_core
      assign qual[s] = pending_o[s];
    end
  end

  assign irq_o  = gie_q & (|qual);
  assign gie_o  = gie_q;
  assign peie_o = peie_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned     NSRC        = 4,
  parameter int unsigned     CW          = 8,
  parameter logic [NSRC-1:0] PERIPH_MASK = 4'b0110,
  parameter logic [7:0]      VEC_ADDR    = 8'h04
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tmr_tick_i,
  input  logic [NSRC-2:0] evt_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic            irq_o,
  output logic [7:0]      vector_o,
  output logic [CW-1:0]   tmr_count_o,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] enables_o,
  output logic            gie_o,
  output logic            peie_o,
  output logic [NSRC-1:0] pending_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_sync_n;
  logic            tmr_wrap;
  logic [NSRC-1:0] set_vec;
  reg_sel_e        sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign sel     = reg_sel_e'(wr_sel_i);
  assign set_vec = {evt_i, tmr_wrap};

  irq_wrap_timer #(.CW(CW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .tick_i  (tmr_tick_i),
    .count_o (tmr_count_o),
    .wrap_o  (tmr_wrap)
  );

  irq_flag_bank #(.NSRC(NSRC)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .set_i     (set_vec),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .flag_o    (flags_o),
    .en_o      (enables_o)
  );

  irq_gate #(.NSRC(NSRC), .PERIPH_MASK(PERIPH_MASK)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .flag_i    (flags_o),
    .en_i      (enables_o),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .ack_i     (ack_i),
    .ret_i     (ret_i),
    .gie_o     (gie_o),
    .peie_o    (peie_o),
    .pending_o (pending_o),
    .irq_o     (irq_o)
  );

  assign vector_o = VEC_ADDR;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned     NSRC        = 4,
  parameter logic [NSRC-1:0] PERIPH_MASK = 4'b0110
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-2:0] evt_i,
  input logic            wr_en_i,
  input logic [1:0]      wr_sel_i,
  input logic            ack_i,
  input logic            ret_i,
  input logic            irq_o,
  input logic [NSRC-1:0] flags_o,
  input logic [NSRC-1:0] pending_o,
  input logic            gie_o
);
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_o); // R4

  AST_ACK_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !gie_o); // R6

  AST_RET_RAISES_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !ack_i) |=> gie_o); // R7

  AST_EVENT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_o[NSRC-1:1] & $past(evt_i)) == $past(evt_i))); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 2'd0) |=> ((~flags_o & $past(flags_o)) == '0)); // R8

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_o && |(pending_o & ~PERIPH_MASK)) |-> irq_o); // R5
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NSRC(NSRC), .PERIPH_MASK(PERIPH_MASK)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .evt_i     (evt_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .ack_i     (ack_i),
  .ret_i     (ret_i),
  .irq_o     (irq_o),
  .flags_o   (flags_o),
  .pending_o (pending_o),
  .gie_o     (gie_o)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
  localparam int NSRC = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            tmr_tick_i;
  logic [NSRC-2:0] evt_i;
  logic            wr_en_i;
  logic [1:0]      wr_sel_i;
  logic [NSRC-1:0] wr_data_i;
  logic            ack_i;
  logic            ret_i;
  logic            irq_o;
  logic [7:0]      vector_o;
  logic [7:0]      tmr_count_o;
  logic [NSRC-1:0] flags_o, enables_o, pending_o;
  logic            gie_o, peie_o;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk_i = ~clk_i;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tmr_tick_i(tmr_tick_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .ack_i(ack_i), .ret_i(ret_i), .irq_o(irq_o), .vector_o(vector_o),
    .tmr_count_o(tmr_count_o), .flags_o(flags_o), .enables_o(enables_o),
    .gie_o(gie_o), .peie_o(peie_o), .pending_o(pending_o)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] sel;
    logic [3:0] data;
    logic [2:0] evt;
    logic       ack;
    logic       ret;
    logic       eirq;
    logic [3:0] eflags;
    logic       egie;
    logic [3:0] epend;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    vec_t'({1'b0, 2'd0, 4'b0000, 3'b001, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 4'b0000}), // R2 src1 while masked
    vec_t'({1'b1, 2'd1, 4'b0010, 3'b000, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 4'b0010}), // R11 enable, no gie
    vec_t'({1'b1, 2'd2, 4'b0001, 3'b000, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b1, 4'b0010}), // R4 group gate closed
    vec_t'({1'b1, 2'd2, 4'b0011, 3'b000, 1'b0, 1'b0, 1'b1, 4'b0010, 1'b1, 4'b0010}), // R10 R4 group open
    vec_t'({1'b0, 2'd0, 4'b0000, 3'b000, 1'b0, 1'b0, 1'b1, 4'b0010, 1'b1, 4'b0010}), // R5 level holds
    vec_t'({1'b0, 2'd0, 4'b0000, 3'b000, 1'b1, 1'b0, 1'b0, 4'b0010, 1'b0, 4'b0010}), // R6 ack
    vec_t'({1'b0, 2'd0, 4'b0000, 3'b000, 1'b0, 1'b1, 1'b1, 4'b0010, 1'b1, 4'b0010}), // R7 retrigger
    vec_t'({1'b1, 2'd0, 4'b1101, 3'b000, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 4'b0000}), // R8 R5 clear drops irq
    vec_t'({1'b0, 2'd0, 4'b0000, 3'b100, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b1, 4'b0000}), // R2 src3 masked
    vec_t'({1'b1, 2'd1, 4'b1000, 3'b000, 1'b0, 1'b0, 1'b1, 4'b1000, 1'b1, 4'b1000}), // R10 late enable
    vec_t'({1'b1, 2'd0, 4'b1111, 3'b000, 1'b0, 1'b0, 1'b1, 4'b1000, 1'b1, 4'b1000}), // R8 ones keep
    vec_t'({1'b1, 2'd0, 4'b0000, 3'b010, 1'b0, 1'b0, 1'b0, 4'b0100, 1'b1, 4'b0000}), // R9 set beats clear
    vec_t'({1'b0, 2'd0, 4'b0000, 3'b000, 1'b1, 1'b1, 1'b0, 4'b0100, 1'b0, 4'b0000})  // R6 ack beats ret
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tmr_tick_i = 1'b0; evt_i = '0; wr_en_i = 1'b0; wr_sel_i = '0;
    wr_data_i = '0; ack_i = 1'b0; ret_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " flags"}, int'(flags_o), 0);
    chk({tag, " enables"}, int'(enables_o), 0);
    chk({tag, " gie"}, int'(gie_o), 0);
    chk({tag, " peie"}, int'(peie_o), 0);
    chk({tag, " irq"}, int'(irq_o), 0);
    chk({tag, " count"}, int'(tmr_count_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    idle_inputs();
    do_reset();
    check_reset_state("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      wr_en_i = TBL[i].we; wr_sel_i = TBL[i].sel; wr_data_i = TBL[i].data;
      evt_i = TBL[i].evt; ack_i = TBL[i].ack; ret_i = TBL[i].ret;
      @(negedge clk_i);
      idle_inputs();
      chk($sformatf("R4 irq step %0d", i), int'(irq_o), int'(TBL[i].eirq));
      chk($sformatf("R2 flags step %0d", i), int'(flags_o), int'(TBL[i].eflags));
      chk($sformatf("R7 gie step %0d", i), int'(gie_o), int'(TBL[i].egie));
      chk($sformatf("R11 pending step %0d", i), int'(pending_o), int'(TBL[i].epend));
    end
    chk("R6 vector", int'(vector_o), 'h04);

    // R3: counter wrap sets flag 0 only on the 256th tick
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = '0;
    @(negedge clk_i);
    idle_inputs();
    tmr_tick_i = 1'b1;
    repeat (255) @(negedge clk_i);
    tmr_tick_i = 1'b0;
    chk("R3 count before wrap", int'(tmr_count_o), 255);
    chk("R3 no flag before wrap", int'(flags_o[0]), 0);
    tmr_tick_i = 1'b1;
    @(negedge clk_i);
    tmr_tick_i = 1'b0;
    chk("R3 count wraps", int'(tmr_count_o), 0);
    chk("R3 flag0 set on wrap", int'(flags_o[0]), 1);

    // R10: source 0 is in the core group, so it needs no group enable
    wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 4'b0001;
    @(negedge clk_i);
    wr_sel_i = 2'd1; wr_data_i = 4'b0001;
    @(negedge clk_i);
    idle_inputs();
    chk("R10 irq after enable", int'(irq_o), 1);

    // R1: reset from a busy state clears everything
    do_reset();
    check_reset_state("R1 second reset");

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule